// File: doc/BRIEF.md
# Paged Parallel Memory Interface Controller

This block is a clocked model of an asynchronous-style parallel memory port sitting in front of a word-wide storage array. The port's control strobes are active low: chip select, write strobe, output enable, two byte-lane enables and a sleep request. A fast system clock samples all of them, and each strobe is edge-detected against its value at the previous clock. When chip select falls, the block latches the row part of the address and starts an access. It delivers read data only once that access has completed. While chip select stays low, the two low address bits may move to reach the other words of the same row at a shorter page latency.

Writes come in two forms. In a select-controlled write, the write strobe is already low when chip select falls. In a strobe-controlled write, the cycle opens as a read and the write strobe falls later. In both forms the data is captured on the first rising edge of either strobe. Writes honour the byte-lane enables and a per-sector protection vector. Releasing chip select starts a precharge window that refuses new cycles. A sleep request ignores every other input and is followed by a wake-up delay. All latencies are parameters counted in system clocks. The storage array is a small register array indexed by the low address bits.

Top module: `pmem_port`

## Requirements
- R1: After reset, both lane drive enables `dq_oe` are 0 and every word of the array reads back as 0.
- R2: A falling edge of `ce_n` with `we_n` high, while awake and outside precharge and wake-up delay, starts a read at the full address. The lanes stay undriven for the first T_ACC clocks, even with `oe_n` low, and are driven from the next clock on.
- R3: Read drive needs `oe_n` low, `ce_n` low and a completed access. Bit 1 of `dq_oe` (data bits 15:8) follows `ub_n` low, and bit 0 (data bits 7:0) follows `lb_n` low.
- R4: While `we_n` is low, `dq_oe` is 0 whatever the state of `oe_n`.
- R5: If `we_n` is already low when `ce_n` falls, the cycle is a write. The value on `din` is stored when `ce_n` rises.
- R6: A read cycle turns into a write on a falling edge of `we_n`. The value on `din` is stored on the following rising edge of `we_n`.
- R7: On a write, a lane whose enable (`ub_n` for bits 15:8, `lb_n` for bits 7:0) is high keeps its stored byte.
- R8: While `ce_n` is low, a change of `addr[1:0]` alone starts a page access in the latched row. It is driven after T_PAGE clocks, with T_PAGE < T_ACC. Each page write needs its own `we_n` pulse.
- R9: While `ce_n` is low, a change of `addr[16:2]` starts a new access with the full latency T_ACC.
- R10: A `ce_n` fall within T_PRE clocks after a `ce_n` rise starts no cycle.
- R11: While `zz_n` is low, all other inputs are ignored and `dq_oe` is 0. A `ce_n` fall within T_ZZX clocks after `zz_n` returns high starts no cycle.
- R12: A write whose sector `addr[16:14]` has its bit set in `wp` completes on the bus but leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper lane enable (bits 15:8), active low |
| lb_n | input | 1 | Lower lane enable (bits 7:0), active low |
| zz_n | input | 1 | Sleep request, active low |
| addr | input | 17 | Word address; bits 1:0 select the column in the row |
| din | input | 16 | Write data |
| wp | input | 8 | Sector protect, bit i guards sector addr[16:14]==i |
| dout | output | 16 | Read data |
| dq_oe | output | 2 | Lane drive enables: bit 1 upper, bit 0 lower |

## Verification
The bench samples the lane enables in the clock just before an access should complete and again in the clock just after. A design that drives early, or that uses the page latency for a change of row, fails at one of these two samples. Masked writes are read back through the other lane. A protected write is placed on an address that aliases an unprotected word, so a design with the wrong sector decode corrupts data that the bench can see. Inputs applied during sleep, and chip-select falls inside the precharge window or the wake-up window, are followed by a read that shows the stored data untouched and the refused cycle never driving.

// File: rtl/pmem_port.sv
module pmem_port #(
  parameter int AW     = 17,
  parameter int BW     = 8,
  parameter int IW     = 6,
  parameter int SB     = 3,
  parameter int T_ACC  = 4,
  parameter int T_PAGE = 2,
  parameter int T_PRE  = 3,
  parameter int T_ZZX  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               ub_n,
  input  logic               lb_n,
  input  logic               zz_n,
  input  logic [AW-1:0]      addr,
  input  logic [2*BW-1:0]    din,
  input  logic [2**SB-1:0]   wp,
  output logic [2*BW-1:0]    dout,
  output logic [1:0]         dq_oe
);
  localparam int DW    = 2 * BW;
  localparam int RW    = AW - 2;
  localparam int DEPTH = 2 ** IW;
  localparam int CW    = $clog2(T_ACC + T_PRE + T_ZZX + 2);

  logic          ce_p, we_p;
  logic [AW-1:0] a_p;
  logic          active, wr_mode, done;
  logic [RW-1:0] row_q;
  logic [1:0]    col_q;
  logic [CW-1:0] acc_cnt, pre_cnt, zz_cnt;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] mem [DEPTH];

  wire ce_fall = ce_p & ~ce_n;
  wire ce_rise = ~ce_p & ce_n;
  wire we_fall = we_p & ~we_n;
  wire we_rise = ~we_p & we_n;
  wire ready   = zz_n && pre_cnt == '0 && zz_cnt == '0;
  wire start   = ce_fall & ready;
  wire hi_chg  = active & ~ce_n & (addr[AW-1:2] != a_p[AW-1:2]);
  wire lo_chg  = active & ~ce_n & (addr[1:0] != a_p[1:0]);
  wire wr_fire = active & wr_mode & (we_rise | ce_rise);

  wire [AW-1:0]  cur_a = {row_q, col_q};
  wire [IW-1:0]  idx   = cur_a[IW-1:0];
  wire [SB-1:0]  sec   = row_q[RW-1 -: SB];
  wire           wr_ok = zz_n & wr_fire & ~wp[sec];
  wire [DW-1:0]  w_old = mem[idx];
  wire           lane_on = zz_n & active & done & ~wr_mode & we_n & ~oe_n & ~ce_n;

  assign dout  = rd_q;
  assign dq_oe = {lane_on & ~ub_n, lane_on & ~lb_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_p <= 1'b1; we_p <= 1'b1; a_p <= '0;
      active <= 1'b0; wr_mode <= 1'b0; done <= 1'b0;
      row_q <= '0; col_q <= '0; rd_q <= '0;
      acc_cnt <= '0; pre_cnt <= '0; zz_cnt <= '0;
    end else begin
      ce_p <= ce_n; we_p <= we_n; a_p <= addr;
      if (!zz_n) begin
        active <= 1'b0; wr_mode <= 1'b0; done <= 1'b0;
        zz_cnt <= CW'(T_ZZX);
      end else begin
        if (zz_cnt != '0) zz_cnt <= zz_cnt - 1'b1;
        if (pre_cnt != '0) pre_cnt <= pre_cnt - 1'b1;
        if (ce_rise) begin
          active <= 1'b0; wr_mode <= 1'b0;
          pre_cnt <= CW'(T_PRE);
        end else if (start) begin
          active <= 1'b1; wr_mode <= ~we_n; done <= 1'b0;
          row_q <= addr[AW-1:2]; col_q <= addr[1:0];
          acc_cnt <= CW'(T_ACC - 1);
        end else if (active) begin
          if (hi_chg) begin
            row_q <= addr[AW-1:2]; col_q <= addr[1:0];
            done <= 1'b0; acc_cnt <= CW'(T_ACC - 1);
          end else if (lo_chg) begin
            col_q <= addr[1:0];
            done <= 1'b0; acc_cnt <= CW'(T_PAGE - 1);
          end else if (wr_fire) begin
            wr_mode <= 1'b0;
            done <= 1'b0; acc_cnt <= CW'(T_PAGE - 1);
          end else if (we_fall) begin
            wr_mode <= 1'b1;
          end else if (!done) begin
            if (acc_cnt == '0) begin
              done <= 1'b1;
              rd_q <= mem[idx];
            end else begin
              acc_cnt <= acc_cnt - 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      if (!ub_n) mem[idx][DW-1:BW] <= din[DW-1:BW];
      if (!lb_n) mem[idx][BW-1:0]  <= din[BW-1:0];
    end
  end

  AST_NO_EARLY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dq_oe == 2'b00)); // R2
  AST_PAGE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (zz_n && lo_chg && !hi_chg) |=> (dq_oe == 2'b00)); // R8
  AST_PRE_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt != '0) |=> !(active && !$past(active))); // R10
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !zz_n |=> (!active && dq_oe == 2'b00)); // R11
  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (zz_n && wr_fire && wp[sec]) |=> (mem[$past(idx)] == $past(w_old))); // R12
endmodule

// File: tb/tb_pmem_port.sv
`timescale 1ns/1ps
module tb_pmem_port;
  localparam int T_ACC = 4, T_PAGE = 2, T_PRE = 3, T_ZZX = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b0, lb_n = 1'b0, zz_n = 1'b1;
  logic [16:0] addr = '0;
  logic [15:0] din = '0;
  logic [7:0]  wp = '0;
  logic [15:0] dout;
  logic [1:0]  dq_oe;
  int checks = 0, failures = 0;

  pmem_port #(.T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_PRE(T_PRE), .T_ZZX(T_ZZX)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .zz_n(zz_n), .addr(addr), .din(din), .wp(wp),
    .dout(dout), .dq_oe(dq_oe));

  always #2.5 clk = ~clk;

  // {write, addr, data, {ub_n,lb_n}, expected}
  localparam logic [51:0] VEC [8] = '{
    {1'b1, 17'h00005, 16'hA1B2, 2'b00, 16'h0000},
    {1'b0, 17'h00005, 16'h0000, 2'b00, 16'hA1B2},
    {1'b1, 17'h00005, 16'hFFFF, 2'b10, 16'h0000},
    {1'b0, 17'h00005, 16'h0000, 2'b00, 16'hA1FF},
    {1'b1, 17'h00006, 16'h1234, 2'b01, 16'h0000},
    {1'b0, 17'h00006, 16'h0000, 2'b01, 16'h1200},
    {1'b0, 17'h00006, 16'h0000, 2'b00, 16'h1200},
    {1'b0, 17'h00007, 16'h0000, 2'b00, 16'h0000}
  };

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [16:0] a, input logic [1:0] ln, input logic [15:0] exp, input string tag);
    logic [15:0] m;
    m = {{8{~ln[1]}}, {8{~ln[0]}}};
    addr = a; {ub_n, lb_n} = ln; oe_n = 1'b0; we_n = 1'b1; ce_n = 1'b0;
    tk(T_ACC);
    chk(dq_oe == 2'b00, {tag, " R2 early"}, dq_oe, 0);
    tk(1);
    chk(dq_oe == ~ln, {tag, " R3 lanes"}, dq_oe, ~ln);
    chk((dout & m) == (exp & m), {tag, " data"}, dout & m, exp & m);
    ce_n = 1'b1; {ub_n, lb_n} = 2'b00;
    tk(T_PRE + 2);
  endtask

  task automatic wr(input logic [16:0] a, input logic [15:0] d, input logic [1:0] ln);
    addr = a; {ub_n, lb_n} = 2'b00; oe_n = 1'b0; we_n = 1'b1; ce_n = 1'b0;
    tk(T_ACC + 1);
    we_n = 1'b0;
    tk(1);
    chk(dq_oe == 2'b00, "R4 we low no drive", dq_oe, 0);
    din = d; {ub_n, lb_n} = ln;
    tk(1);
    we_n = 1'b1;
    tk(1);
    ce_n = 1'b1; {ub_n, lb_n} = 2'b00;
    tk(T_PRE + 2);
  endtask

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tk(3);
    chk(dq_oe == 2'b00, "R1 reset lanes", dq_oe, 0);
    rst_n = 1'b1;
    tk(2);
    rd(17'h00009, 2'b00, 16'h0000, "R1 reset array");

    // R6 R7 R3: table of strobe-controlled writes and reads
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][51]) wr(VEC[i][50:34], VEC[i][33:18], VEC[i][17:16]);
      else rd(VEC[i][50:34], VEC[i][17:16], VEC[i][15:0], $sformatf("R6 R7 vec%0d", i));
    end

    // R5: select-controlled write, captured on ce_n rise
    addr = 17'h00010; din = 16'hBEEF; oe_n = 1'b0; we_n = 1'b0; ce_n = 1'b0;
    tk(T_ACC + 2);
    chk(dq_oe == 2'b00, "R5 R4 no drive in write", dq_oe, 0);
    ce_n = 1'b1;
    tk(1);
    we_n = 1'b1;
    tk(T_PRE + 2);
    rd(17'h00010, 2'b00, 16'hBEEF, "R5 readback");

    // R8: page writes, one strobe each
    addr = 17'h00020; we_n = 1'b1; ce_n = 1'b0;
    tk(T_ACC + 1);
    for (int c = 0; c < 4; c++) begin
      addr = 17'h00020 | 17'(c);
      tk(T_PAGE + 1);
      we_n = 1'b0;
      tk(1);
      din = 16'h3C00 + 16'(c);
      tk(1);
      we_n = 1'b1;
      tk(1);
    end
    ce_n = 1'b1;
    tk(T_PRE + 2);

    // R8 page read, then R9 row change
    addr = 17'h00020; oe_n = 1'b0; ce_n = 1'b0;
    tk(T_ACC + 1);
    chk(dout == 16'h3C00, "R8 first word", dout, 16'h3C00);
    addr = 17'h00023;
    tk(T_PAGE);
    chk(dq_oe == 2'b00, "R8 page early", dq_oe, 0);
    tk(1);
    chk(dq_oe == 2'b11 && dout == 16'h3C03, "R8 page data", {dq_oe, dout}, {2'b11, 16'h3C03});
    addr = 17'h00005;
    tk(T_PAGE + 1);
    chk(dq_oe == 2'b00, "R9 row change full latency", dq_oe, 0);
    tk(T_ACC - T_PAGE);
    chk(dq_oe == 2'b11 && dout == 16'hA1FF, "R9 row data", {dq_oe, dout}, {2'b11, 16'hA1FF});

    // R10: fall inside precharge refused
    ce_n = 1'b1;
    tk(1);
    ce_n = 1'b0;
    tk(T_ACC + 3);
    chk(dq_oe == 2'b00, "R10 refused in precharge", dq_oe, 0);
    ce_n = 1'b1;
    tk(T_PRE + 3);
    ce_n = 1'b0;
    tk(T_ACC + 1);
    chk(dq_oe == 2'b11 && dout == 16'hA1FF, "R10 accepted after", {dq_oe, dout}, {2'b11, 16'hA1FF});

    // R11: sleep with an open cycle, ignored write, wake-up delay
    zz_n = 1'b0;
    tk(1);
    chk(dq_oe == 2'b00, "R11 sleep no drive", dq_oe, 0);
    ce_n = 1'b1;
    tk(T_PRE + 2);
    din = 16'h0000; we_n = 1'b0; ce_n = 1'b0;
    tk(T_ACC + 2);
    ce_n = 1'b1;
    tk(1);
    we_n = 1'b1;
    tk(2);
    zz_n = 1'b1;
    tk(2);
    ce_n = 1'b0;
    tk(T_ACC + 3);
    chk(dq_oe == 2'b00, "R11 refused in wake delay", dq_oe, 0);
    ce_n = 1'b1;
    tk(T_PRE + T_ZZX + 2);
    rd(17'h00005, 2'b00, 16'hA1FF, "R11 sleep write ignored");

    // R12: sector protect, decoded from addr[16:14]
    wp = 8'h80;
    wr(17'h1C005, 16'h0000, 2'b00);
    rd(17'h00005, 2'b00, 16'hA1FF, "R12 protected unchanged");
    wp = 8'h7F;
    wr(17'h1C005, 16'h5A5A, 2'b00);
    rd(17'h1C005, 2'b00, 16'h5A5A, "R12 unprotected written");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule